// File: doc/BRIEF.md
# JTAG Data-Register Bus Master Bridge

This block gives a debug probe single-word access to an on-chip Wishbone bus through the data-register path of an existing TAP controller. The TAP controller supplies the selected 4-bit instruction and one-cycle qualifiers that mark its Capture-DR, Shift-DR, Update-DR and Test-Logic-Reset states. The bridge decodes three instruction values into its own scan chains and runs a Wishbone master state machine that performs one transfer per request.

One instruction loads a 16-bit bus address into a held address register. Any number of later accesses reuse that address until it is loaded again. A second instruction starts a read when its scan reaches Update-DR. The returned word is kept in a read-data register, and the next capture of either data chain shifts it out. A third instruction shifts in a 16-bit write word and issues the write on Update-DR. The word the slave returns with its acknowledge is kept in the same read-data register, so the following scan can return it.

Top module: `jwb_bridge`

## Requirements
- R1: Instruction value 8 selects the address chain, 9 the read chain and 10 the write-read chain. `chain_sel` is 1 exactly for these three values. For any other value `tdo` is 0 and neither the address register nor any bus output changes.
- R2: Every chain is 16 bits long and moves least significant bit first. After Capture-DR, `tdo` shows bit 0. Each Shift-DR cycle presents the next bit and loads `tdi` into bit 15.
- R3: Capture-DR on the address chain loads the current address register. Update-DR on it copies the shifted word into the address register, which then stays unchanged across later accesses.
- R4: Update-DR on the read chain while the bus is idle drives `wb_cyc`=`wb_stb`=1 and `wb_we`=0 from the next cycle, with `wb_adr` equal to the address register.
- R5: Update-DR on the write-read chain while idle drives `wb_cyc`=`wb_stb`=`wb_we`=1, `wb_dat_w` equal to the shifted-in word and `wb_adr` equal to the address register. All of these hold steady until `wb_ack`.
- R6: `wb_cyc` and `wb_stb` drop in the cycle after the one in which `wb_ack` is seen. The `wb_dat_r` sampled with that acknowledge, for a read or a write, is what the next Capture-DR of the read or write-read chain presents.
- R7: Update-DR on the read or write-read chain while a transfer is in progress is ignored. The transfer continues unchanged and no second transfer follows it.
- R8: `wb_ack` while no transfer is in progress is ignored, and the read-data register keeps its value.
- R9: Test-Logic-Reset clears the address register to 0 and ends any transfer: `wb_cyc`, `wb_stb` and `wb_we` are 0 in the next cycle, and an aborted read does not change the read-data register.
- R10: After `rst_n`, all bus outputs are 0 and both the address register and the read-data register hold 0.
- R11: With the address register at 0x0018, a write-read of 0xFEEF followed by a read of the same address returns 0xFEEF on the second read-chain capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the TAP state qualifiers and the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| tap_capture_dr | input | 1 | TAP is in Capture-DR this cycle |
| tap_shift_dr | input | 1 | TAP is in Shift-DR this cycle |
| tap_update_dr | input | 1 | TAP is in Update-DR this cycle |
| ir_code | input | 4 | Currently selected instruction |
| tdi | input | 1 | Serial data into the selected chain |
| tdo | output | 1 | Serial data out of the selected chain, 0 when none is selected |
| chain_sel | output | 1 | One of the bridge's chains is selected |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 16 | Bus address |
| wb_dat_w | output | 16 | Write data |
| wb_dat_r | input | 16 | Read data from the slave |
| wb_ack | input | 1 | Slave acknowledge |

## Verification
A corrupted address or read-data register shows up at `tdo` on the next capture of its chain, which is within one scan of the fault. A master state machine stuck busy shows up as `wb_cyc` still high in the cycle after an acknowledge. A state machine that accepts a second request shows up as a change in `wb_we` or `wb_dat_w` during a transfer, in the cycle after the stray Update-DR. A wrong write or a wrong latch on acknowledge is caught by the write-then-read pass over sixteen addresses, when the following read-chain scan returns a word that differs from the expected one.

// File: rtl/jwb_pkg.sv
package jwb_pkg;

  typedef enum logic [0:0] {
    BUS_IDLE   = 1'b0,
    BUS_ACTIVE = 1'b1
  } bus_state_t;

  // serial output mux: address chain wins, then the shared data chain
  function automatic logic pick_tdo(input logic sel_a, input logic sel_d,
                                    input logic bit_a, input logic bit_d);
    if (sel_a)      return bit_a;
    else if (sel_d) return bit_d;
    else            return 1'b0;
  endfunction

endpackage

// File: rtl/jwb_ir_decode.sv
module jwb_ir_decode #(
  parameter int IR_W      = 4,
  parameter int CODE_ADDR = 8,
  parameter int CODE_READ = 9,
  parameter int CODE_WRRD = 10
) (
  input  logic [IR_W-1:0] ir_code,
  output logic            sel_addr,
  output logic            sel_read,
  output logic            sel_wrrd,
  output logic            sel_any
);
  localparam logic [IR_W-1:0] K_ADDR = IR_W'(CODE_ADDR);
  localparam logic [IR_W-1:0] K_READ = IR_W'(CODE_READ);
  localparam logic [IR_W-1:0] K_WRRD = IR_W'(CODE_WRRD);

  assign sel_addr = (ir_code == K_ADDR);
  assign sel_read = (ir_code == K_READ);
  assign sel_wrrd = (ir_code == K_WRRD);
  assign sel_any  = sel_addr | sel_read | sel_wrrd;
endmodule

// File: rtl/jwb_dr_chain.sv
module jwb_dr_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic [W-1:0] sr,
  output logic         sr_tdo
);
  // one LSB-first step: new bit enters at the top
  function automatic logic [W-1:0] step_in(input logic [W-1:0] cur, input logic b);
    return {b, cur[W-1:1]};
  endfunction

  logic do_cap, do_shift;
  assign do_cap   = sel & capture;
  assign do_shift = sel & shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (clr)      sr <= '0;
    else if (do_cap)   sr <= cap_val;
    else if (do_shift) sr <= step_in(sr, tdi);
  end

  assign sr_tdo = sr[0];

  assert_shift_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift && !clr |=> sr[W-1] == $past(tdi));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_cap && !clr |=> sr == $past(cap_val));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel && !clr |=> $stable(sr));
endmodule

// File: rtl/jwb_wb_master.sv
module jwb_wb_master
  import jwb_pkg::*;
#(
  parameter int ADR_W = 16,
  parameter int DAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             req_rd,
  input  logic             req_wr,
  input  logic [ADR_W-1:0] req_adr,
  input  logic [DAT_W-1:0] req_dat,
  output logic             wb_cyc,
  output logic             wb_stb,
  output logic             wb_we,
  output logic [ADR_W-1:0] wb_adr,
  output logic [DAT_W-1:0] wb_dat_w,
  input  logic [DAT_W-1:0] wb_dat_r,
  input  logic             wb_ack,
  output logic [DAT_W-1:0] rdata
);
  bus_state_t st;
  logic       accept_ev;   // request taken this cycle
  logic       done_ev;     // acknowledge completes the transfer
  logic       ignored_ev;  // request arrives while busy

  assign accept_ev  = (st == BUS_IDLE) & (req_rd | req_wr) & ~abort;
  assign done_ev    = (st == BUS_ACTIVE) & wb_ack & ~abort;
  assign ignored_ev = (st == BUS_ACTIVE) & (req_rd | req_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= BUS_IDLE;
      wb_we    <= 1'b0;
      wb_adr   <= '0;
      wb_dat_w <= '0;
      rdata    <= '0;
    end else if (abort) begin
      st    <= BUS_IDLE;
      wb_we <= 1'b0;
    end else if (accept_ev) begin
      st     <= BUS_ACTIVE;
      wb_we  <= req_wr;
      wb_adr <= req_adr;
      if (req_wr) wb_dat_w <= req_dat;
    end else if (done_ev) begin
      st    <= BUS_IDLE;
      wb_we <= 1'b0;
      rdata <= wb_dat_r;
    end
  end

  assign wb_cyc = (st == BUS_ACTIVE);
  assign wb_stb = (st == BUS_ACTIVE);

  assert_drop_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && wb_ack |=> !wb_cyc && !wb_stb);

  assert_latch_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> rdata == $past(wb_dat_r));

  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && !wb_ack && !abort |=> wb_cyc && $stable(wb_we) && $stable(wb_adr) && $stable(wb_dat_w));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_ev && !wb_ack && !abort |=> wb_cyc && $stable(wb_we));

  assert_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_cyc |=> $stable(rdata));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !wb_cyc && !wb_we && $stable(rdata));

  assert_we_only_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> wb_cyc);
endmodule

// File: rtl/jwb_bridge.sv
module jwb_bridge
  import jwb_pkg::*;
#(
  parameter int IR_W      = 4,
  parameter int ADR_W     = 16,
  parameter int DAT_W     = 16,
  parameter int CODE_ADDR = 8,
  parameter int CODE_READ = 9,
  parameter int CODE_WRRD = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_reset,
  input  logic             tap_capture_dr,
  input  logic             tap_shift_dr,
  input  logic             tap_update_dr,
  input  logic [IR_W-1:0]  ir_code,
  input  logic             tdi,
  output logic             tdo,
  output logic             chain_sel,
  output logic             wb_cyc,
  output logic             wb_stb,
  output logic             wb_we,
  output logic [ADR_W-1:0] wb_adr,
  output logic [DAT_W-1:0] wb_dat_w,
  input  logic [DAT_W-1:0] wb_dat_r,
  input  logic             wb_ack
);
  logic             sel_addr, sel_read, sel_wrrd, sel_data;
  logic [ADR_W-1:0] addr_q;
  logic [ADR_W-1:0] addr_sr;
  logic [DAT_W-1:0] data_sr;
  logic [DAT_W-1:0] rdata;
  logic             addr_tdo, data_tdo;
  logic             addr_load_ev;
  logic             start_rd_ev, start_wr_ev;

  jwb_ir_decode #(
    .IR_W(IR_W), .CODE_ADDR(CODE_ADDR), .CODE_READ(CODE_READ), .CODE_WRRD(CODE_WRRD)
  ) u_dec (
    .ir_code  (ir_code),
    .sel_addr (sel_addr),
    .sel_read (sel_read),
    .sel_wrrd (sel_wrrd),
    .sel_any  (chain_sel)
  );

  assign sel_data = sel_read | sel_wrrd;

  jwb_dr_chain #(.W(ADR_W)) u_addr_chain (
    .clk (clk), .rst_n (rst_n), .clr (tap_reset), .sel (sel_addr),
    .capture (tap_capture_dr), .shift (tap_shift_dr),
    .cap_val (addr_q), .tdi (tdi), .sr (addr_sr), .sr_tdo (addr_tdo)
  );

  jwb_dr_chain #(.W(DAT_W)) u_data_chain (
    .clk (clk), .rst_n (rst_n), .clr (tap_reset), .sel (sel_data),
    .capture (tap_capture_dr), .shift (tap_shift_dr),
    .cap_val (rdata), .tdi (tdi), .sr (data_sr), .sr_tdo (data_tdo)
  );

  assign addr_load_ev = tap_update_dr & sel_addr & ~tap_reset;
  assign start_rd_ev  = tap_update_dr & sel_read;
  assign start_wr_ev  = tap_update_dr & sel_wrrd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr_q <= '0;
    else if (tap_reset)    addr_q <= '0;
    else if (addr_load_ev) addr_q <= addr_sr;
  end

  jwb_wb_master #(.ADR_W(ADR_W), .DAT_W(DAT_W)) u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (tap_reset),
    .req_rd   (start_rd_ev),
    .req_wr   (start_wr_ev),
    .req_adr  (addr_q),
    .req_dat  (data_sr),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_w (wb_dat_w),
    .wb_dat_r (wb_dat_r),
    .wb_ack   (wb_ack),
    .rdata    (rdata)
  );

  assign tdo = pick_tdo(sel_addr, sel_data, addr_tdo, data_tdo);

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_addr && !tap_reset |=> $stable(addr_q));

  assert_addr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load_ev |=> addr_q == $past(addr_sr));

  assert_addr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> addr_q == '0);

  assert_start_adr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd_ev || start_wr_ev) && !wb_cyc && !tap_reset |=> wb_cyc && wb_adr == $past(addr_q));

  assert_tdo_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_sel |-> !tdo);
endmodule

// File: tb/tb_jwb_bridge.sv
module tb_jwb_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tap_reset = 1'b0, tap_capture_dr = 1'b0, tap_shift_dr = 1'b0, tap_update_dr = 1'b0;
  logic [3:0]  ir_code = 4'd0;
  logic        tdi = 1'b0;
  logic        tdo, chain_sel;
  logic        wb_cyc, wb_stb, wb_we;
  logic [15:0] wb_adr, wb_dat_w, wb_dat_r;
  logic        wb_ack;

  int checks = 0, errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  jwb_bridge dut (
    .clk, .rst_n, .tap_reset, .tap_capture_dr, .tap_shift_dr, .tap_update_dr,
    .ir_code, .tdi, .tdo, .chain_sel, .wb_cyc, .wb_stb, .wb_we, .wb_adr,
    .wb_dat_w, .wb_dat_r, .wb_ack
  );

  // ---------------- slave model ----------------
  logic [15:0] mem [16];
  int          lat = 0;
  int          cnt;
  logic        slv_ack;
  logic [15:0] slv_dat;
  logic        stray = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'h0;
      slv_ack <= 1'b0; slv_dat <= 16'h0; cnt <= 0;
    end else if (slv_ack) begin
      slv_ack <= 1'b0;
    end else if (wb_cyc && wb_stb) begin
      if (cnt >= lat) begin
        slv_ack <= 1'b1;
        slv_dat <= mem[wb_adr[3:0]];
        if (wb_we) mem[wb_adr[3:0]] <= wb_dat_w;
        cnt <= 0;
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  assign wb_ack   = slv_ack | stray;
  assign wb_dat_r = stray ? 16'hDEAD : slv_dat;

  // expected memory contents, kept by the bench
  logic [15:0] model [16];

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // full data-register scan: capture, 16 shifts, update; ends at the negedge after update
  task automatic dr_scan(input logic [3:0] code, input logic [15:0] din, output logic [15:0] dout);
    @(negedge clk);
    ir_code = code;
    tap_capture_dr = 1'b1;
    @(negedge clk);
    tap_capture_dr = 1'b0;
    tap_shift_dr = 1'b1;
    for (int i = 0; i < 16; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      @(negedge clk);
    end
    tap_shift_dr = 1'b0;
    tap_update_dr = 1'b1;
    @(negedge clk);
    tap_update_dr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && wb_cyc; i++) @(negedge clk);
    chk("R6 transfer completes", {31'b0, wb_cyc}, 32'h0);
  endtask

  // follows a running transfer, checks R5 stability and R6 drop timing
  task automatic follow_transfer(input logic we_exp, input logic [15:0] adr_exp, input logic [15:0] dat_exp);
    int n = 0;
    while (!wb_ack && n < 100) begin
      if (wb_cyc !== 1'b1 || wb_we !== we_exp || wb_adr !== adr_exp || (we_exp && wb_dat_w !== dat_exp)) begin
        chk("R5 outputs steady until ack", {wb_cyc, wb_we, wb_adr}, {1'b1, we_exp, adr_exp});
      end
      @(negedge clk); n++;
    end
    chk("R5 ack reached", {31'b0, wb_ack}, 32'h1);
    @(negedge clk);
    chk("R6 cyc/stb low after ack", {wb_cyc, wb_stb}, 2'b00);
  endtask

  logic [15:0] d;

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 bus idle after reset", {wb_cyc, wb_stb, wb_we}, 3'b000);
    chk("R10 no chain for code 0", {31'b0, chain_sel}, 32'h0);
    dr_scan(4'd8, 16'h0018, d);
    chk("R10 address register zero", d, 16'h0000);

    // R1 decode sweep
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); ir_code = 4'(c);
      #1 chk($sformatf("R1 chain_sel for code %0d", c), {31'b0, chain_sel}, (c >= 8 && c <= 10) ? 32'h1 : 32'h0);
    end

    // R3 address chain returns previous value, LSB first (R2)
    dr_scan(4'd8, 16'hA5C3, d); chk("R3 address readback 0x0018", d, 16'h0018);
    dr_scan(4'd8, 16'h8001, d); chk("R2 R3 address readback 0xA5C3", d, 16'hA5C3);
    dr_scan(4'd8, 16'hFFFF, d); chk("R2 R3 address readback 0x8001", d, 16'h8001);

    // R1 unrelated code: tdo quiet, address untouched
    dr_scan(4'd4, 16'h7777, d); chk("R1 tdo zero on other code", d, 16'h0000);
    chk("R1 bus idle on other code", {31'b0, wb_cyc}, 32'h0);
    dr_scan(4'd8, 16'h0018, d); chk("R1 address kept across other code", d, 16'hFFFF);

    // R5 R11 write 0xFEEF to 0x18
    lat = 3;
    dr_scan(4'd10, 16'hFEEF, d);
    chk("R5 write strobes", {wb_cyc, wb_stb, wb_we}, 3'b111);
    chk("R5 write address", wb_adr, 16'h0018);
    chk("R5 write data", wb_dat_w, 16'hFEEF);
    follow_transfer(1'b1, 16'h0018, 16'hFEEF);
    model[8] = 16'hFEEF;

    // R4 R11 read back
    dr_scan(4'd9, 16'h0, d);
    chk("R6 capture after write returns old word", d, 16'h0000);
    chk("R4 read strobes", {wb_cyc, wb_stb, wb_we}, 3'b110);
    chk("R4 read address", wb_adr, 16'h0018);
    follow_transfer(1'b0, 16'h0018, 16'h0);
    dr_scan(4'd9, 16'h0, d);
    chk("R11 read returns 0xFEEF", d, 16'hFEEF);
    wait_idle();

    // R6 write-read returns the displaced word
    dr_scan(4'd10, 16'h1234, d);
    wait_idle();
    model[8] = 16'h1234;
    dr_scan(4'd9, 16'h0, d);
    chk("R6 write-read returns previous contents", d, 16'hFEEF);
    wait_idle();

    // sweep: write then read every slot, with varying latency
    for (int a = 0; a < 16; a++) begin
      logic [15:0] v, old;
      v = 16'(a * 16'h1111) ^ 16'h5A5A;
      old = model[a];
      lat = a % 4;
      dr_scan(4'd8, 16'h0020 + 16'(a), d);
      dr_scan(4'd10, v, d);
      wait_idle();
      model[a] = v;
      dr_scan(4'd9, 16'h0, d);
      chk($sformatf("R6 slot %0d write returns old", a), d, old);
      wait_idle();
      dr_scan(4'd9, 16'h0, d);
      chk($sformatf("R3 R4 slot %0d read back", a), d, v);
      wait_idle();
    end

    // R7 request while busy is ignored
    lat = 8;
    dr_scan(4'd8, 16'h0023, d);
    dr_scan(4'd10, 16'hC0DE, d);
    @(negedge clk); ir_code = 4'd9; tap_update_dr = 1'b1;
    @(negedge clk); tap_update_dr = 1'b0;
    chk("R7 write kept during stray read update", {wb_cyc, wb_we}, 2'b11);
    chk("R7 write data kept", wb_dat_w, 16'hC0DE);
    wait_idle();
    model[3] = 16'hC0DE;
    repeat (4) @(negedge clk);
    chk("R7 no queued transfer", {31'b0, wb_cyc}, 32'h0);
    lat = 0;
    dr_scan(4'd9, 16'h0, d);   // capture old word, start read of slot 3
    wait_idle();
    dr_scan(4'd9, 16'h0, d);
    chk("R7 single write landed", d, 16'hC0DE);
    wait_idle();

    // R8 stray ack while idle
    @(negedge clk); stray = 1'b1;
    @(negedge clk); stray = 1'b0;
    dr_scan(4'd9, 16'h0, d);
    chk("R8 stray ack ignored", d, 16'hC0DE);
    wait_idle();

    // R9 Test-Logic-Reset aborts a read and clears the address
    lat = 8;
    dr_scan(4'd8, 16'h0025, d);
    dr_scan(4'd9, 16'h0, d);
    chk("R9 read started before abort", {31'b0, wb_cyc}, 32'h1);
    @(negedge clk); tap_reset = 1'b1;
    @(negedge clk); tap_reset = 1'b0;
    chk("R9 bus dropped by reset", {wb_cyc, wb_stb, wb_we}, 3'b000);
    lat = 0;
    dr_scan(4'd8, 16'h0000, d);
    chk("R9 address cleared", d, 16'h0000);
    dr_scan(4'd9, 16'h0, d);
    chk("R9 aborted read not latched", d, 16'hC0DE);
    wait_idle();

    finish_run();
  end
endmodule